// File: doc/BRIEF.md
# Parallel Port Bus Interface

A small processor-bus peripheral with twenty-four general-purpose I/O lines. There are two full-width ports, A and B, and a third port, C, split into an upper and a lower half. Each port or half is either an input or an output. An output holds the last value written to it. An input returns whatever is on its pins. The bus side has a chip select, a two-bit address, read and write strobes and an active-low asynchronous reset.

Direction is set through a configuration location that can only be written. The lines form two configuration groups of twelve: group 0 is port A with upper C, and group 1 is port B with lower C. One configuration write can update either group, both groups or neither, while the other group keeps its settings. Each pin output has a matching output-enable vector, which drives an external tri-state pad.

Top module: `pio_bus_port`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every output enable is 0, every output latch is 0, and every port reads as an input.
- R2: With `cs_i` high, address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register.
- R3: A configuration write uses these bits, where 1 means output: bit 0 for port A, bit 1 for upper C, bit 2 for port B and bit 3 for lower C. Bit 6 enables the update of group 0 (bits 0 and 1). Bit 7 enables the update of group 1 (bits 2 and 3). A group whose enable bit is clear keeps its directions.
- R4: Each output latch drives its port's pin outputs at all times. An output enable is all ones when its port or half is an output and all zeros when it is an input. The latch keeps its value until the next write to that port.
- R5: A write is captured on the rising clock edge only when `cs_i` and `wr_i` are both high. With `cs_i` low, a write strobe has no effect.
- R6: Reading a port or half that is an input returns its pin values combinationally.
- R7: Reading a port or half that is an output returns its latch contents.
- R8: A read of port C returns each half according to that half's own direction, so pin bits and latch bits can appear in the same byte.
- R9: A read of address 3 returns zero.
- R10: `data_oe_o` is high only while `cs_i` and `rd_i` are both high. At all other times `data_o` is zero.
- R11: A write to a port set as input still loads its latch. The new value is driven and read back once the port is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| addr_i | input | 2 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| data_i | input | PORT_W | Write data |
| data_o | output | PORT_W | Read data |
| data_oe_o | output | 1 | Read data bus drive enable |
| pa_i | input | PORT_W | Port A pins in |
| pa_o | output | PORT_W | Port A latch out |
| pa_oe_o | output | PORT_W | Port A output enable |
| pb_i | input | PORT_W | Port B pins in |
| pb_o | output | PORT_W | Port B latch out |
| pb_oe_o | output | PORT_W | Port B output enable |
| pc_i | input | PORT_W | Port C pins in |
| pc_o | output | PORT_W | Port C latch out |
| pc_oe_o | output | PORT_W | Port C output enable, upper half over bits PORT_W-1..PORT_W/2 |

## Verification
The bench builds the block with the default PORT_W of 8, which is the smallest width that holds every configuration bit. At this width the upper and lower halves of port C are 4-bit nibbles. The bench drives different constant patterns onto each half, so a mixed-direction read of port C gives a result that is neither the pin value nor the latch value. The bench also moves one group between input and output while the other group keeps its setting, which exposes any cross-talk between the two group enables.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CFG = 2'd3
  } pio_sel_e;

  // direction bits, 1 = output; a at bit 0
  typedef struct packed {
    logic c_lo;
    logic b;
    logic c_hi;
    logic a;
  } pio_dir_t;

  localparam int unsigned CFG_GRP0_BIT = 6;
  localparam int unsigned CFG_GRP1_BIT = 7;
endpackage

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PORT_W-1:0] wdata_i,
  output pio_dir_t          dir_o
);
  pio_dir_t dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (wr_en_i) begin
      if (wdata_i[CFG_GRP0_BIT]) begin
        dir_q.a    <= wdata_i[0];
        dir_q.c_hi <= wdata_i[1];
      end
      if (wdata_i[CFG_GRP1_BIT]) begin
        dir_q.b    <= wdata_i[2];
        dir_q.c_lo <= wdata_i[3];
      end
    end
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/pio_lane.sv
module pio_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic         dir_out_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] latch_q;

  // latch loads regardless of direction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= '0;
    else if (wr_en_i) latch_q <= wdata_i;
  end

  assign pin_o    = latch_q;
  assign pin_oe_o = {W{dir_out_i}};
  assign rdata_o  = dir_out_i ? latch_q : pin_i;
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              cs_i,
  input  logic              rd_i,
  input  pio_sel_e          sel_i,
  input  logic [PORT_W-1:0] a_i,
  input  logic [PORT_W-1:0] b_i,
  input  logic [PORT_W-1:0] c_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [PORT_W-1:0] sel_data;

  always_comb begin
    unique case (sel_i)
      SEL_A:   sel_data = a_i;
      SEL_B:   sel_data = b_i;
      SEL_C:   sel_data = c_i;
      default: sel_data = '0;  // config is write-only
    endcase
  end

  assign data_oe_o = cs_i & rd_i;
  assign data_o    = data_oe_o ? sel_data : '0;
endmodule

// File: rtl/pio_bus_port.sv
module pio_bus_port
  import pio_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [1:0]        addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  localparam int unsigned NIB_W = PORT_W / 2;

  pio_sel_e          sel;
  logic              wr_hit;
  logic              wr_a, wr_b, wr_c, wr_cfg;
  pio_dir_t          dir;
  logic [PORT_W-1:0] a_rd, b_rd, c_rd;
  logic [1:0]        c_dir;

  assign sel    = pio_sel_e'(addr_i);
  assign wr_hit = cs_i & wr_i;
  assign wr_a   = wr_hit && (sel == SEL_A);
  assign wr_b   = wr_hit && (sel == SEL_B);
  assign wr_c   = wr_hit && (sel == SEL_C);
  assign wr_cfg = wr_hit && (sel == SEL_CFG);

  pio_cfg_reg #(.PORT_W(PORT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_cfg),
    .wdata_i (data_i),
    .dir_o   (dir)
  );

  pio_lane #(.W(PORT_W)) u_lane_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_a),
    .wdata_i   (data_i),
    .dir_out_i (dir.a),
    .pin_i     (pa_i),
    .pin_o     (pa_o),
    .pin_oe_o  (pa_oe_o),
    .rdata_o   (a_rd)
  );

  pio_lane #(.W(PORT_W)) u_lane_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_b),
    .wdata_i   (data_i),
    .dir_out_i (dir.b),
    .pin_i     (pb_i),
    .pin_o     (pb_o),
    .pin_oe_o  (pb_oe_o),
    .rdata_o   (b_rd)
  );

  // index 0 = lower half, 1 = upper half
  assign c_dir = {dir.c_hi, dir.c_lo};

  for (genvar h = 0; h < 2; h++) begin : g_c_half
    pio_lane #(.W(NIB_W)) u_lane_c (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_c),
      .wdata_i   (data_i[h*NIB_W +: NIB_W]),
      .dir_out_i (c_dir[h]),
      .pin_i     (pc_i[h*NIB_W +: NIB_W]),
      .pin_o     (pc_o[h*NIB_W +: NIB_W]),
      .pin_oe_o  (pc_oe_o[h*NIB_W +: NIB_W]),
      .rdata_o   (c_rd[h*NIB_W +: NIB_W])
    );
  end

  pio_rd_mux #(.PORT_W(PORT_W)) u_rd_mux (
    .cs_i      (cs_i),
    .rd_i      (rd_i),
    .sel_i     (sel),
    .a_i       (a_rd),
    .b_i       (b_rd),
    .c_i       (c_rd),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/pio_bus_port_chk.sv
module pio_bus_port_chk #(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic [1:0]        addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [PORT_W-1:0] data_i,
  input logic [PORT_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [PORT_W-1:0] pa_o,
  input logic [PORT_W-1:0] pa_oe_o,
  input logic [PORT_W-1:0] pb_oe_o,
  input logic [PORT_W-1:0] pc_oe_o
);
  localparam int unsigned NIB_W = PORT_W / 2;

  logic wr_a, wr_cfg;
  assign wr_a   = cs_i && wr_i && (addr_i == 2'd0);
  assign wr_cfg = cs_i && wr_i && (addr_i == 2'd3);

  a_r4_oe_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_oe_o == '0 || pa_oe_o == '1) && (pb_oe_o == '0 || pb_oe_o == '1));

  a_r8_c_half_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_oe_o[NIB_W-1:0] == '0 || pc_oe_o[NIB_W-1:0] == '1);

  a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_a |=> $stable(pa_o));

  a_r5_write_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a |=> pa_o == $past(data_i));

  a_r3_dir_only_on_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  a_r10_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> (data_o == '0) && !data_oe_o);

  a_r9_cfg_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == 2'd3) |-> data_oe_o && (data_o == '0));
endmodule

bind pio_bus_port pio_bus_port_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/pio_bus_port_bench.sv
module pio_bus_port_bench;
  localparam int unsigned PORT_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0]        addr_i = '0;
  logic [PORT_W-1:0] data_i = '0;
  logic [PORT_W-1:0] data_o;
  logic              data_oe_o;
  logic [PORT_W-1:0] pa_i = 8'h5A, pb_i = 8'hC3, pc_i = 8'h96;
  logic [PORT_W-1:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int tests = 0;
  int fails = 0;

  logic [PORT_W-1:0] exp_q[$];
  string             tag_q[$];
  event              smp_ev;

  always #10 clk_i = ~clk_i;

  pio_bus_port #(.PORT_W(PORT_W)) u_pio_bus_port (.*);

  task automatic chk(input logic [PORT_W-1:0] got, input logic [PORT_W-1:0] exp,
                     input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compare bus read data against scoreboard
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      automatic logic [PORT_W-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(data_o, e, t);
      chk({7'd0, data_oe_o}, 8'd1, {t, " (R10 oe)"});
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [PORT_W-1:0] d,
                        input logic sel = 1'b1);
    @(negedge clk_i);
    cs_i = sel; wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0; data_i = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [PORT_W-1:0] exp,
                        input string tag);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    #2 ->smp_ev;
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #35;
    chk(pa_oe_o | pb_oe_o | pc_oe_o, 8'h00, "R1 oe in reset");
    chk(pa_o | pb_o | pc_o, 8'h00, "R1 latches in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pa_oe_o | pb_oe_o | pc_oe_o, 8'h00, "R1 oe after reset");

    bus_rd(2'd0, 8'h5A, "R6 R2 read A pins");
    bus_rd(2'd1, 8'hC3, "R6 R2 read B pins");
    bus_rd(2'd2, 8'h96, "R6 R2 read C pins");
    bus_rd(2'd3, 8'h00, "R9 cfg read");

    bus_wr(2'd0, 8'h11);
    bus_rd(2'd0, 8'h5A, "R11 input A still reads pins");
    chk(pa_oe_o, 8'h00, "R11 A not driven");

    // group 0 apply, A out; group 1 fields set but not applied
    bus_wr(2'd3, 8'h45);
    chk(pa_oe_o, 8'hFF, "R3 A out");
    chk(pb_oe_o, 8'h00, "R3 B untouched without group 1 enable");
    chk(pc_oe_o, 8'h00, "R3 C halves input");
    chk(pa_o, 8'h11, "R11 latch driven after switch");
    bus_rd(2'd0, 8'h11, "R7 R11 read A latch");

    // group 1 apply: C lower out, B in
    bus_wr(2'd3, 8'h88);
    chk(pc_oe_o, 8'h0F, "R8 C lower out only");
    chk(pa_oe_o, 8'hFF, "R3 group 0 kept");

    bus_wr(2'd2, 8'hA5);
    chk(pc_o, 8'hA5, "R4 C latch");
    bus_rd(2'd2, 8'h95, "R8 mixed C read");

    bus_wr(2'd0, 8'hEE, 1'b0);
    chk(pa_o, 8'h11, "R5 write without cs ignored");

    repeat (3) @(negedge clk_i);
    chk(pa_o, 8'h11, "R4 latch holds");
    chk(data_o, 8'h00, "R10 idle data");
    chk({7'd0, data_oe_o}, 8'h00, "R10 idle oe");

    bus_wr(2'd1, 8'h77);
    bus_wr(2'd3, 8'h84);
    chk(pb_oe_o, 8'hFF, "R3 B out");
    chk(pc_oe_o, 8'h00, "R3 C lower back to input");
    bus_rd(2'd1, 8'h77, "R7 read B latch");
    bus_rd(2'd2, 8'h96, "R6 C pins again");

    pa_i = 8'h3C;
    bus_rd(2'd0, 8'h11, "R7 output A ignores pins");

    bus_wr(2'd3, 8'h40);
    bus_rd(2'd0, 8'h3C, "R6 A back to input");

    @(negedge clk_i);
    rst_ni = 1'b0;
    #3;
    chk(pa_oe_o | pb_oe_o | pc_oe_o, 8'h00, "R1 oe on reset");
    chk(pa_o | pb_o | pc_o, 8'h00, "R1 latches cleared");
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_rd(2'd1, 8'hC3, "R1 B input after reset");

    @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule